// File: doc/BRIEF.md
# Manual flash encryption control block

This block is the software-facing control and status front end of a manual flash encryption engine. Software fills a 64-byte plaintext buffer and programs a line size, a target selector and a physical flash address. It then writes a start command. The block checks that the address is aligned to the chosen line, and it asks an external cipher engine to compute through a start/done handshake. The cipher arithmetic is not part of this block; the engine only sees the buffer and the configuration as flat buses.

When the engine reports completion, the result is marked valid but is still hidden from the flash serial interface. It becomes visible only after software issues an explicit release command. A destroy command then discards the result, wipes the plaintext buffer and returns the block to idle. All registers sit on a plain 32-bit word bus with combinational read data. Writes take effect at the clock edge.

Top module: `fcrypt_ctrl`

## Requirements
- R1: After reset the state field reads 0, the line-size, target and address registers read 0, the version register reads decimal 538969635, and eng_start, res_valid, spi_expose and err_misalign are 0.
- R2: Four read/write registers: bit 0 at offset 0x40 (line size: 0 selects 16-byte lines, 1 selects 32-byte lines), bit 0 at 0x44 (target: 0 is flash, 1 is reserved), bits [29:0] at 0x48 (physical address) and bits [29:0] at 0x5C (version). Unused bits read 0. These registers drive eng_line32, eng_dest and eng_addr.
- R3: The state field is bits [1:0] at offset 0x58, encoded 0 idle, 1 working, 2 result hidden, 3 result exposed. Writing 1 to bit 0 at offset 0x4C while idle, with an aligned address, gives state 1 in the next cycle and a single-cycle eng_start pulse in that same cycle.
- R4: The address is aligned when bits [3:0] are zero (16-byte lines) or bits [4:0] are zero (32-byte lines). A start command in idle with a misaligned address leaves the state idle, gives no eng_start, and sets err_misalign. err_misalign stays set until the next start command that begins a calculation.
- R5: eng_done while working moves the state to 2, with res_valid=1 and spi_expose=0. eng_done in any other state is ignored.
- R6: Writing 1 to bit 0 at offset 0x50 in state 2 moves the state to 3 with spi_expose=1. In any other state the command is ignored.
- R7: A start command is ignored (no eng_start, no state change) when the state is not idle.
- R8: Writing 1 to bit 0 at offset 0x54 in state 2 or 3 returns the state to idle, clears res_valid and spi_expose, and zeroes every plaintext word. In state 0 or 1 the command is ignored.
- R9: Offsets 0x4C, 0x50 and 0x54, and any unmapped offset, always read 0.
- R10: The plaintext buffer is 16 read/write words at offsets 0x00 to 0x3C. Word k appears at eng_plain[32k+31:32k], so byte b of the buffer (flash address mod 64) sits at eng_plain[8b+7:8b].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Word write strobe for the current cycle |
| bus_addr | input | 7 | Byte offset of the accessed word (bits [1:0] ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| eng_start | output | 1 | Single-cycle request to the cipher engine |
| eng_line32 | output | 1 | Line-size selection to the engine |
| eng_dest | output | 1 | Target selection to the engine |
| eng_addr | output | 30 | Physical flash address to the engine |
| eng_plain | output | 512 | Flattened plaintext buffer |
| eng_done | input | 1 | Completion pulse from the engine |
| res_valid | output | 1 | Result exists (hidden or exposed) |
| spi_expose | output | 1 | Result visible to the flash serial side |
| err_misalign | output | 1 | Sticky alignment error |

## Verification
On every cycle the assertions check the lifecycle ordering. A start pulse only leaves the idle state. Working holds until done, and an exposed result only leaves through destroy. Exposure always implies a valid result, and the alignment error falls only when a calculation starts. The bench scenarios show what a property cannot see at the ports: reset values, readback of every register, the placement of plaintext words on the engine bus, and the wipe of the buffer on destroy. They also show that commands in the wrong state leave every observable value unchanged.

// File: rtl/fcrypt_pkg.sv
package fcrypt_pkg;

    localparam int DATA_W   = 32;
    localparam int BUS_AW   = 7;
    localparam int PADDR_W  = 30;
    localparam int VER_W    = 30;
    localparam logic [VER_W-1:0] VER_RST = 30'd538969635;

    // word offsets (byte offset >> 2) of the control registers
    localparam logic [BUS_AW-3:0] WOFS_LINE  = 5'h10;
    localparam logic [BUS_AW-3:0] WOFS_DEST  = 5'h11;
    localparam logic [BUS_AW-3:0] WOFS_PADDR = 5'h12;
    localparam logic [BUS_AW-3:0] WOFS_START = 5'h13;
    localparam logic [BUS_AW-3:0] WOFS_REL   = 5'h14;
    localparam logic [BUS_AW-3:0] WOFS_KILL  = 5'h15;
    localparam logic [BUS_AW-3:0] WOFS_STATE = 5'h16;
    localparam logic [BUS_AW-3:0] WOFS_VER   = 5'h17;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WORK   = 2'd1,
        ST_HIDDEN = 2'd2,
        ST_EXPOSE = 2'd3
    } life_st_t;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_PLAIN, SEL_LINE, SEL_DEST, SEL_PADDR,
        SEL_START, SEL_REL, SEL_KILL, SEL_STATE, SEL_VER
    } reg_sel_t;

    typedef struct packed {
        logic start;
        logic rel;
        logic kill;
    } life_cmd_t;

    typedef struct packed {
        logic                line32;
        logic                dest;
        logic [PADDR_W-1:0]  paddr;
        logic [VER_W-1:0]    ver;
    } cfg_t;

    function automatic logic addr_aligned(input logic [PADDR_W-1:0] a, input logic line32);
        if (line32)
            return (a[4:0] == 5'd0);
        return (a[3:0] == 4'd0);
    endfunction

endpackage

// File: rtl/fcrypt_regdec.sv
module fcrypt_regdec
    import fcrypt_pkg::*;
#(
    parameter int BUF_BYTES = 64
) (
    input  logic [BUS_AW-1:0] addr,
    output reg_sel_t          sel
);
    localparam int BUF_AW = $clog2(BUF_BYTES);

    logic [BUS_AW-3:0] word;
    assign word = addr[BUS_AW-1:2];

    always_comb begin
        sel = SEL_NONE;
        if (addr[BUS_AW-1:BUF_AW] == '0) begin
            sel = SEL_PLAIN;
        end else begin
            case (word)
                WOFS_LINE:  sel = SEL_LINE;
                WOFS_DEST:  sel = SEL_DEST;
                WOFS_PADDR: sel = SEL_PADDR;
                WOFS_START: sel = SEL_START;
                WOFS_REL:   sel = SEL_REL;
                WOFS_KILL:  sel = SEL_KILL;
                WOFS_STATE: sel = SEL_STATE;
                WOFS_VER:   sel = SEL_VER;
                default:    sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/fcrypt_plainbuf.sv
module fcrypt_plainbuf
    import fcrypt_pkg::*;
#(
    parameter int BUF_BYTES = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [$clog2(BUF_BYTES/4)-1:0] wr_idx,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      wipe,
    input  logic [$clog2(BUF_BYTES/4)-1:0] rd_idx,
    output logic [DATA_W-1:0]         rd_data,
    output logic [BUF_BYTES*8-1:0]    flat
);
    localparam int WORDS = BUF_BYTES / 4;

    logic [DATA_W-1:0] mem [WORDS];

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || wipe)
                mem[k] <= '0;
            else if (wr_en && wr_idx == k[$clog2(WORDS)-1:0])
                mem[k] <= wr_data;
        end
        assign flat[k*DATA_W +: DATA_W] = mem[k];
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/fcrypt_cfgregs.sv
module fcrypt_cfgregs
    import fcrypt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  reg_sel_t          sel,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.line32 <= 1'b0;
            cfg.dest   <= 1'b0;
            cfg.paddr  <= '0;
            cfg.ver    <= VER_RST;
        end else if (wr) begin
            case (sel)
                SEL_LINE:  cfg.line32 <= wdata[0];
                SEL_DEST:  cfg.dest   <= wdata[0];
                SEL_PADDR: cfg.paddr  <= wdata[PADDR_W-1:0];
                SEL_VER:   cfg.ver    <= wdata[VER_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fcrypt_lifecycle.sv
module fcrypt_lifecycle
    import fcrypt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  life_cmd_t cmd,
    input  logic      aligned,
    input  logic      done,
    output life_st_t  st,
    output logic      start_pulse,
    output logic      err,
    output logic      wipe
);
    life_st_t st_n;
    logic     go;

    assign go   = cmd.start && (st == ST_IDLE) && aligned;
    assign wipe = cmd.kill && (st == ST_HIDDEN || st == ST_EXPOSE);

    always_comb begin
        st_n = st;
        case (st)
            ST_IDLE:   if (go) st_n = ST_WORK;
            ST_WORK:   if (done) st_n = ST_HIDDEN;
            ST_HIDDEN: begin
                if (cmd.kill)     st_n = ST_IDLE;
                else if (cmd.rel) st_n = ST_EXPOSE;
            end
            ST_EXPOSE: if (cmd.kill) st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            start_pulse <= 1'b0;
            err         <= 1'b0;
        end else begin
            st          <= st_n;
            start_pulse <= go;
            if (go)
                err <= 1'b0;
            else if (cmd.start && st == ST_IDLE)
                err <= 1'b1;
        end
    end
endmodule

// File: rtl/fcrypt_ctrl.sv
module fcrypt_ctrl
    import fcrypt_pkg::*;
#(
    parameter int BUF_BYTES = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic [BUS_AW-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   eng_start,
    output logic                   eng_line32,
    output logic                   eng_dest,
    output logic [PADDR_W-1:0]     eng_addr,
    output logic [BUF_BYTES*8-1:0] eng_plain,
    input  logic                   eng_done,
    output logic                   res_valid,
    output logic                   spi_expose,
    output logic                   err_misalign
);
    localparam int IDX_W = $clog2(BUF_BYTES / 4);

    reg_sel_t          sel;
    cfg_t              cfg;
    life_cmd_t         cmd;
    life_st_t          st_q;
    logic              wipe;
    logic [DATA_W-1:0] buf_rd;
    logic [IDX_W-1:0]  idx;

    assign idx = bus_addr[IDX_W+1:2];

    fcrypt_regdec #(.BUF_BYTES(BUF_BYTES)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    fcrypt_cfgregs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    fcrypt_plainbuf #(.BUF_BYTES(BUF_BYTES)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr && sel == SEL_PLAIN),
        .wr_idx  (idx),
        .wr_data (bus_wdata),
        .wipe    (wipe),
        .rd_idx  (idx),
        .rd_data (buf_rd),
        .flat    (eng_plain)
    );

    always_comb begin
        cmd.start = bus_wr && sel == SEL_START && bus_wdata[0];
        cmd.rel   = bus_wr && sel == SEL_REL   && bus_wdata[0];
        cmd.kill  = bus_wr && sel == SEL_KILL  && bus_wdata[0];
    end

    fcrypt_lifecycle u_life (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .aligned     (addr_aligned(cfg.paddr, cfg.line32)),
        .done        (eng_done),
        .st          (st_q),
        .start_pulse (eng_start),
        .err         (err_misalign),
        .wipe        (wipe)
    );

    always_comb begin
        case (sel)
            SEL_PLAIN: bus_rdata = buf_rd;
            SEL_LINE:  bus_rdata = {{(DATA_W-1){1'b0}}, cfg.line32};
            SEL_DEST:  bus_rdata = {{(DATA_W-1){1'b0}}, cfg.dest};
            SEL_PADDR: bus_rdata = {{(DATA_W-PADDR_W){1'b0}}, cfg.paddr};
            SEL_STATE: bus_rdata = {{(DATA_W-2){1'b0}}, st_q};
            SEL_VER:   bus_rdata = {{(DATA_W-VER_W){1'b0}}, cfg.ver};
            default:   bus_rdata = '0;
        endcase
    end

    assign eng_line32 = cfg.line32;
    assign eng_dest   = cfg.dest;
    assign eng_addr   = cfg.paddr;
    assign res_valid  = (st_q == ST_HIDDEN) || (st_q == ST_EXPOSE);
    assign spi_expose = (st_q == ST_EXPOSE);
endmodule

// File: rtl/fcrypt_chk.sv
module fcrypt_chk
    import fcrypt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] st,
    input logic       eng_start,
    input logic       eng_done,
    input logic       res_valid,
    input logic       spi_expose,
    input logic       err
);
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> (st == ST_WORK && $past(st) == ST_IDLE)); // R3

    AST_ERR_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
        $fell(err) |-> eng_start); // R4

    AST_WORK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WORK && !eng_done) |=> st == ST_WORK); // R5

    AST_EXPOSE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        spi_expose |-> res_valid); // R6

    AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (rst)
        st == ST_IDLE |=> (st == ST_IDLE || st == ST_WORK)); // R7

    AST_EXPOSE_EXIT: assert property (@(posedge clk) disable iff (rst)
        st == ST_EXPOSE |=> (st == ST_EXPOSE || st == ST_IDLE)); // R8
endmodule

bind fcrypt_ctrl fcrypt_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .st         (st_q),
    .eng_start  (eng_start),
    .eng_done   (eng_done),
    .res_valid  (res_valid),
    .spi_expose (spi_expose),
    .err        (err_misalign)
);

// File: tb/sim_fcrypt_ctrl.sv
module sim_fcrypt_ctrl;
    localparam logic [6:0] A_LINE = 7'h40, A_DEST = 7'h44, A_PADDR = 7'h48,
                           A_GO = 7'h4C, A_REL = 7'h50, A_KILL = 7'h54,
                           A_ST = 7'h58, A_VER = 7'h5C;

    logic         clk = 0;
    logic         rst = 1;
    logic         bus_wr = 0;
    logic [6:0]   bus_addr = 0;
    logic [31:0]  bus_wdata = 0;
    logic [31:0]  bus_rdata;
    logic         eng_start, eng_line32, eng_dest, eng_done = 0;
    logic [29:0]  eng_addr;
    logic [511:0] eng_plain;
    logic         res_valid, spi_expose, err_misalign;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    int          st_m;
    bit          err_m;
    bit          line_m;
    logic [29:0] addr_m;
    logic [31:0] buf_m [16];

    always #2.5 clk = ~clk;

    fcrypt_ctrl u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start),
        .eng_line32(eng_line32), .eng_dest(eng_dest), .eng_addr(eng_addr),
        .eng_plain(eng_plain), .eng_done(eng_done), .res_valid(res_valid),
        .spi_expose(spi_expose), .err_misalign(err_misalign)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        eng_done = 1;
        @(negedge clk);
        eng_done = 0;
    endtask

    function automatic bit aligned_m(input logic [29:0] a, input bit l32);
        return l32 ? (a[4:0] == 0) : (a[3:0] == 0);
    endfunction

    task automatic check_status(input string tag);
        logic [31:0] v;
        rd(A_ST, v);
        chk({tag, " state"}, v, 32'(st_m));
        chk({tag, " res_valid"}, 32'(res_valid), 32'(st_m >= 2));
        chk({tag, " spi_expose"}, 32'(spi_expose), 32'(st_m == 3));
        chk({tag, " err_misalign"}, 32'(err_misalign), 32'(err_m));
    endtask

    task automatic do_start();
        bit exp_go;
        exp_go = (st_m == 0) && aligned_m(addr_m, line_m);
        wr(A_GO, 1);
        chk(exp_go ? "R3 start pulse" : "R7/R4 no start pulse", 32'(eng_start), 32'(exp_go));
        if (st_m == 0) begin
            if (exp_go) begin st_m = 1; err_m = 0; end
            else err_m = 1;
        end
        @(negedge clk);
        chk("R3 pulse one cycle", 32'(eng_start), 0);
    endtask

    task automatic do_kill();
        wr(A_KILL, 1);
        if (st_m >= 2) begin
            st_m = 0;
            for (int k = 0; k < 16; k++) buf_m[k] = 0;
        end
    endtask

    task automatic check_buf(input string tag);
        logic [31:0] v;
        for (int k = 0; k < 16; k++) begin
            rd(7'(k * 4), v);
            chk({tag, " R10 readback"}, v, buf_m[k]);
            chk({tag, " R10 engine word"}, eng_plain[k*32 +: 32], buf_m[k]);
        end
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        st_m = 0; err_m = 0; line_m = 0; addr_m = 0;
        for (int k = 0; k < 16; k++) buf_m[k] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset values
        rd(A_ST, v);    chk("R1 state", v, 0);
        rd(A_LINE, v);  chk("R1 line", v, 0);
        rd(A_DEST, v);  chk("R1 dest", v, 0);
        rd(A_PADDR, v); chk("R1 paddr", v, 0);
        rd(A_VER, v);   chk("R1 version", v, 32'd538969635);
        chk("R1 outputs", {28'd0, eng_start, res_valid, spi_expose, err_misalign}, 0);

        // R2 register readback and engine drive
        wr(A_LINE, 32'hFFFF_FFFF); rd(A_LINE, v); chk("R2 line", v, 1);
        chk("R2 eng_line32", 32'(eng_line32), 1);
        wr(A_DEST, 32'hFFFF_FFFF); rd(A_DEST, v); chk("R2 dest", v, 1);
        chk("R2 eng_dest", 32'(eng_dest), 1);
        wr(A_DEST, 0);
        wr(A_PADDR, 32'hFFFF_FFFF); rd(A_PADDR, v); chk("R2 paddr", v, 32'h3FFF_FFFF);
        chk("R2 eng_addr", 32'(eng_addr), 32'h3FFF_FFFF);
        wr(A_VER, 32'hFFFF_FFFF); rd(A_VER, v); chk("R2 version", v, 32'h3FFF_FFFF);
        line_m = 1; addr_m = 30'h3FFF_FFFF;

        // R9 command offsets and holes read zero
        rd(A_GO, v);   chk("R9 start reads 0", v, 0);
        rd(A_REL, v);  chk("R9 release reads 0", v, 0);
        rd(A_KILL, v); chk("R9 destroy reads 0", v, 0);
        rd(7'h7C, v);  chk("R9 unmapped reads 0", v, 0);

        // R4 misaligned: 32-byte line with address 0x10
        wr(A_PADDR, 32'h10); addr_m = 30'h10;
        do_start(); check_status("R4 misaligned 32");
        // 16-byte line with 0x10 is aligned: error clears on start
        wr(A_LINE, 0); line_m = 0;
        do_start(); check_status("R4 aligned clears");
        // R7 start while working ignored
        do_start(); check_status("R7 start in work");
        // R6 release while working ignored
        wr(A_REL, 1); check_status("R6 release in work");
        // R8 destroy while working ignored
        do_kill(); check_status("R8 kill in work");
        pulse_done(); st_m = 2; check_status("R5 done");
        pulse_done(); check_status("R5 extra done ignored");
        wr(A_REL, 1); st_m = 3; check_status("R6 release");

        // random phase
        for (int it = 0; it < 600; it++) begin
            int op;
            op = $urandom_range(0, 5);
            case (op)
                0: do_start();
                1: begin wr(A_REL, 1); if (st_m == 2) st_m = 3; end
                2: do_kill();
                3: begin pulse_done(); if (st_m == 1) st_m = 2; end
                4: begin
                    int k; logic [31:0] d;
                    k = $urandom_range(0, 15); d = $urandom;
                    wr(7'(k * 4), d); buf_m[k] = d;
                end
                default: begin
                    logic [29:0] a;
                    a = 30'($urandom);
                    if ($urandom_range(0, 1) == 1) a = {a[29:5], 5'd0};
                    line_m = $urandom_range(0, 1);
                    wr(A_LINE, 32'(line_m));
                    wr(A_PADDR, 32'(a)); addr_m = a;
                end
            endcase
            check_status("R3 random");
            if (it % 50 == 0) check_buf("random");
        end

        // R8 destroy wipes buffer from exposed state
        for (int k = 0; k < 16; k++) begin
            buf_m[k] = 32'hA5A5_0000 + 32'(k);
            wr(7'(k * 4), buf_m[k]);
        end
        check_buf("R10 directed");
        if (st_m == 1) begin pulse_done(); st_m = 2; end
        if (st_m == 0) begin
            wr(A_PADDR, 0); addr_m = 0;
            do_start(); pulse_done(); st_m = 2;
        end
        if (st_m == 2) begin wr(A_REL, 1); st_m = 3; end
        check_status("R6 before destroy");
        do_kill(); check_status("R8 destroy");
        check_buf("R8 wiped");

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule